// File: doc/BRIEF.md
# Periodic Reset Interval Controller

This block counts wakeup pulses that arrive from an external wakeup timer. Software programs an interval of 1 to 63 wakeups. When that many pulses have arrived, the block raises a one-clock reset request toward the system reset logic and starts counting again from zero. A sticky flag records that a periodic reset happened. Only power-on reset clears this flag, so software can still see it after the system reset it caused. Software clears it by writing a one to the acknowledge bit.

An interval of zero turns periodic reset off. The block accepts a zero interval only while the wakeup timer is configured to a nonzero setting. This guard keeps periodic wakeup and periodic reset from both being switched off. Writing a different interval restarts the count. Writing the interval already held leaves the count running. A read strobe captures the 8-bit control/status view and the current counter value into output registers. The bench sees both values on the clock after the strobe, and they hold until the next read.

Top module: `periodic_reset_ctrl`

## Requirements
- R1: With a nonzero interval N, the N-th wakeup pulse after a restart makes `reset_req` high for the following clock only, and the internal count returns to 0.
- R2: Power-on reset and general reset both preset the interval field to 63 and clear the count. After power-on reset a read returns 8'h3F with a count of 0.
- R3: A write whose bits 5:0 differ from the held interval, and that is accepted, loads the new interval and restarts the count at 0. A write of the held value leaves the count unchanged.
- R4: A write of 0 to bits 5:0 is accepted only while `wake_timer_nz` is 1. While `wake_timer_nz` is 0 such a write leaves the interval unchanged.
- R5: While the interval is 0, the count stays at 0 and `reset_req` never rises, whatever wakeup pulses arrive.
- R6: Bit 7 of the status view is a flag that sets on every periodic reset request. Writes to bit 7 do not change it.
- R7: Writing 1 to bit 6 clears the flag. Writing 0 to bit 6 leaves the flag as it is. Bit 6 always reads 0.
- R8: If a periodic reset request and a flag acknowledge fall in the same cycle, the flag ends up set.
- R9: Only `por` clears the flag. A general reset (`rst`) leaves it unchanged.
- R10: A cycle with `rd_en` high captures {flag, 0, interval} into `rd_data` and the counter into `cnt_snap`, visible after that clock edge. Both hold their value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| rst | input | 1 | Synchronous active-high general reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 6 acknowledges the flag, bits 5:0 set the interval |
| rd_en | input | 1 | Read strobe; captures the status view and the count |
| wake_pulse | input | 1 | One-cycle wakeup interrupt from the wakeup timer |
| wake_timer_nz | input | 1 | High while the wakeup-timer setting is nonzero |
| rd_data | output | 8 | Captured view: bit 7 flag, bit 6 zero, bits 5:0 interval |
| reset_req | output | 1 | One-clock periodic reset request |
| cnt_snap | output | 6 | Counter value captured on the last read |

## Verification
Two events can land in the same cycle: the terminal wakeup pulse that sets the flag, and a software write that acknowledges the flag. To provoke this, the bench programs an interval of 2, delivers one wakeup, and then drives the second wakeup together with a write of 8'h42. That write acknowledges the flag and repeats the held interval, so it does not restart the count. The bench judges the outcome at the ports: `reset_req` must pulse on the next clock, and the following read must show bit 7 set. A second case checks that a write carrying a new interval, arriving in the same cycle as the would-be terminal pulse, restarts the count so that no request is issued.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // Outcome of a register write as seen by the interval field
  typedef enum logic [1:0] {
    IW_NONE  = 2'd0,  // no write this cycle
    IW_KEEP  = 2'd1,  // same value written: no change, no restart
    IW_LOAD  = 2'd2,  // new value accepted: load and restart
    IW_BLOCK = 2'd3   // zero refused while wakeup timer is off
  } ival_wr_e;
endpackage

// File: rtl/prc_interval_reg.sv
module prc_interval_reg
  import prc_pkg::*;
#(
  parameter int IVAL_W = 6
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              wr_en,
  input  logic [IVAL_W-1:0] wr_val,
  input  logic              timer_nz,
  output logic [IVAL_W-1:0] ival,
  output logic              restart
);
  ival_wr_e act;

  always_comb begin
    if (!wr_en)                        act = IW_NONE;
    else if (wr_val == ival)           act = IW_KEEP;
    else if (wr_val == '0 && !timer_nz) act = IW_BLOCK;
    else                               act = IW_LOAD;
  end

  assign restart = (act == IW_LOAD);

  always_ff @(posedge clk) begin
    if (rst_any)      ival <= '1;
    else if (restart) ival <= wr_val;
  end
endmodule

// File: rtl/prc_wake_counter.sv
module prc_wake_counter #(
  parameter int IVAL_W = 6
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              restart,
  input  logic              wake,
  input  logic [IVAL_W-1:0] ival,
  output logic [IVAL_W-1:0] cnt,
  output logic              term,
  output logic              req
);
  localparam int EXT_W = IVAL_W + 1;

  logic             active;
  logic [EXT_W-1:0] cnt_inc;

  assign active  = (ival != '0);
  assign cnt_inc = {1'b0, cnt} + EXT_W'(1);
  assign term    = wake && active && !restart && (cnt_inc == {1'b0, ival});

  always_ff @(posedge clk) begin
    if (rst_any) begin
      cnt <= '0;
      req <= 1'b0;
    end else begin
      req <= term;
      if (restart || term || !active) cnt <= '0;
      else if (wake)                  cnt <= cnt_inc[IVAL_W-1:0];
    end
  end
endmodule

// File: rtl/prc_flag.sv
module prc_flag (
  input  logic clk,
  input  logic por,
  input  logic rst,
  input  logic set_evt,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (por)          flag <= 1'b0;
    else if (rst)     flag <= flag;
    else if (set_evt) flag <= 1'b1;   // set wins over a same-cycle ack
    else if (ack)     flag <= 1'b0;
  end
endmodule

// File: rtl/periodic_reset_ctrl.sv
module periodic_reset_ctrl #(
  parameter int IVAL_W = 6,
  parameter int DATA_W = IVAL_W + 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wake_pulse,
  input  logic              wake_timer_nz,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req,
  output logic [IVAL_W-1:0] cnt_snap
);
  localparam int FLAG_POS = DATA_W - 1;
  localparam int ACK_POS  = DATA_W - 2;

  logic              rst_any;
  logic              wr_live;
  logic [IVAL_W-1:0] ival_q;
  logic [IVAL_W-1:0] cnt_q;
  logic              restart;
  logic              term;
  logic              flag_q;

  assign rst_any = por | rst;
  assign wr_live = wr_en & ~rst_any;

  prc_interval_reg #(.IVAL_W(IVAL_W)) u_ival (
    .clk      (clk),
    .rst_any  (rst_any),
    .wr_en    (wr_live),
    .wr_val   (wr_data[IVAL_W-1:0]),
    .timer_nz (wake_timer_nz),
    .ival     (ival_q),
    .restart  (restart)
  );

  prc_wake_counter #(.IVAL_W(IVAL_W)) u_cnt (
    .clk     (clk),
    .rst_any (rst_any),
    .restart (restart),
    .wake    (wake_pulse),
    .ival    (ival_q),
    .cnt     (cnt_q),
    .term    (term),
    .req     (reset_req)
  );

  prc_flag u_flag (
    .clk     (clk),
    .por     (por),
    .rst     (rst),
    .set_evt (term),
    .ack     (wr_live & wr_data[ACK_POS]),
    .flag    (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst_any) begin
      rd_data  <= '0;
      cnt_snap <= '0;
    end else if (rd_en) begin
      rd_data  <= '0;
      rd_data[FLAG_POS]     <= flag_q;
      rd_data[IVAL_W-1:0]   <= ival_q;
      cnt_snap <= cnt_q;
    end
  end
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int IVAL_W = 6,
  parameter int DATA_W = IVAL_W + 2
) (
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wake_timer_nz,
  input logic              reset_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag_q,
  input logic [IVAL_W-1:0] ival_q,
  input logic [IVAL_W-1:0] cnt_q
);
  a_r1_req_clears_cnt: assert property (@(posedge clk) disable iff (por || rst)
    reset_req |-> cnt_q == '0);

  a_r2_preset_63: assert property (@(posedge clk) disable iff (por)
    rst |=> ival_q == '1);

  a_r3_restart: assert property (@(posedge clk) disable iff (por || rst)
    (wr_en && wr_data[IVAL_W-1:0] != ival_q &&
     (wr_data[IVAL_W-1:0] != '0 || wake_timer_nz)) |=> cnt_q == '0);

  a_r4_zero_guard: assert property (@(posedge clk) disable iff (por || rst)
    (wr_en && wr_data[IVAL_W-1:0] == '0 && !wake_timer_nz) |=> $stable(ival_q));

  a_r5_zero_quiet: assert property (@(posedge clk) disable iff (por || rst)
    ival_q == '0 |=> !reset_req && cnt_q == '0);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (por || rst)
    reset_req |-> flag_q);

  a_r9_flag_kept: assert property (@(posedge clk) disable iff (por)
    rst |=> $stable(flag_q));

  always_comb begin
    a_r7_bit6_zero: assert (rd_data[DATA_W-2] == 1'b0);
  end
endmodule

bind periodic_reset_ctrl prc_checker #(.IVAL_W(IVAL_W), .DATA_W(DATA_W)) u_prc_chk (
  .clk           (clk),
  .por           (por),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .wake_timer_nz (wake_timer_nz),
  .reset_req     (reset_req),
  .rd_data       (rd_data),
  .flag_q        (flag_q),
  .ival_q        (ival_q),
  .cnt_q         (cnt_q)
);

// File: tb/test_periodic_reset_ctrl.sv
`timescale 1ns/1ps
module test_periodic_reset_ctrl;
  logic       clk = 1'b0;
  logic       por = 1'b1, rst = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, wake_pulse = 1'b0, wake_timer_nz = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       reset_req;
  logic [5:0] cnt_snap;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic last_req;
  int   req_seen;

  always #5 clk = ~clk;

  periodic_reset_ctrl i_periodic_reset_ctrl (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .wake_pulse(wake_pulse), .wake_timer_nz(wake_timer_nz),
    .rd_data(rd_data), .reset_req(reset_req), .cnt_snap(cnt_snap)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; samples reset_req after the edge
  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic wk);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; wake_pulse = wk;
    @(posedge clk); #1;
    last_req = reset_req;
    if (reset_req) req_seen++;
    wr_en = 0; rd_en = 0; wake_pulse = 0;
  endtask

  task automatic wakes(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1);
  endtask

  task automatic do_read();
    step(0, 8'h00, 1, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); por = 1; @(negedge clk); por = 0;
    chk("R2 reset_req idle", reset_req, 0);
    do_read();
    chk("R2 read after por", rd_data, 8'h3F);
    chk("R10 count after por", cnt_snap, 0);
  endtask

  task automatic t_basic();
    step(1, 8'h03, 0, 0);
    req_seen = 0;
    wakes(2);
    chk("R1 no early request", req_seen, 0);
    do_read();
    chk("R10 count two", cnt_snap, 2);
    chk("R6 flag clear before", rd_data[7], 0);
    wakes(1);
    chk("R1 request on third wake", last_req, 1);
    step(0, 8'h00, 0, 0);
    chk("R1 request one clock", last_req, 0);
    do_read();
    chk("R6 flag set", rd_data, 8'h83);
    chk("R1 count back to zero", cnt_snap, 0);
  endtask

  task automatic t_rewrite();
    wakes(1);
    step(1, 8'h03, 0, 0);
    do_read();
    chk("R3 same value keeps count", cnt_snap, 1);
    wakes(1);
    step(1, 8'h05, 0, 0);
    do_read();
    chk("R3 new value restarts", cnt_snap, 0);
    chk("R3 new value loaded", rd_data[5:0], 5);
    // new interval in same cycle as would-be terminal wake: no request
    step(1, 8'h02, 0, 0); wakes(1);
    step(1, 8'h07, 0, 1);
    chk("R3 restart beats terminal", last_req, 0);
  endtask

  task automatic t_ack();
    step(1, 8'h87, 0, 0);
    do_read();
    chk("R6 write bit7 leaves flag", rd_data[7], 1);
    step(1, 8'h07, 0, 0);
    do_read();
    chk("R7 zero in bit6 no effect", rd_data[7], 1);
    step(1, 8'h47, 0, 0);
    do_read();
    chk("R7 ack clears flag", rd_data, 8'h07);
  endtask

  task automatic t_zero();
    wake_timer_nz = 0;
    step(1, 8'h00, 0, 0);
    do_read();
    chk("R4 zero refused", rd_data[5:0], 7);
    wake_timer_nz = 1;
    step(1, 8'h00, 0, 0);
    do_read();
    chk("R4 zero accepted", rd_data[5:0], 0);
    req_seen = 0;
    wakes(70);
    do_read();
    chk("R5 no request at zero", req_seen, 0);
    chk("R5 count held", cnt_snap, 0);
  endtask

  task automatic t_race();
    step(1, 8'h02, 0, 0);
    wakes(1);
    step(1, 8'h42, 0, 1);
    chk("R8 request issued", last_req, 1);
    do_read();
    chk("R8 set beats ack", rd_data, 8'h82);
  endtask

  task automatic t_rst();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    do_read();
    chk("R9 flag survives rst", rd_data[7], 1);
    chk("R2 rst presets 63", rd_data[5:0], 63);
    @(negedge clk); por = 1; @(negedge clk); por = 0;
    do_read();
    chk("R9 por clears flag", rd_data[7], 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_rewrite();
    t_ack();
    t_zero();
    t_race();
    t_rst();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule